// File: doc/BRIEF.md
# Multi-Function PCI Configuration Header

This block holds the type-0 configuration header dwords for a PCI device that exposes four functions: an ISA bridge (function 0), an IDE controller (function 1), a USB controller (function 2) and a power-management function (function 3). A configuration access arrives as one request cycle carrying a function number, a dword index, 32 bits of write data and four byte enables. Reads return the selected dword one clock later with a valid strobe; writes land on the clock edge of the request.

Each function keeps four header dwords: identity (device and vendor ID), command/status, class code with revision, and the dword holding the header type. The identity, class and header-type dwords are loaded with their fixed values on reset and never change afterwards. Only the command/status dword accepts writes. A parameter chooses between two update rules for it: a whole-dword rule and a per-byte rule. Function numbers above 3 and dword indices above 3 decode to nothing.

Top module: `pcfg_header`

## Requirements
- R1: After reset, dword 0 reads 0x71108086, 0x71118086, 0x71128086 and 0x71138086 for functions 0, 1, 2 and 3; the low 16 bits read 0x8086 at all times.
- R2: After reset, dword 2 reads 0x06010000, 0x01018000, 0x0C030000 and 0x06800000 for functions 0, 1, 2 and 3.
- R3: After reset, dword 3 reads 0x00800000 for function 0 (multi-function flag in bit 23) and 0 for functions 1 to 3.
- R4: After reset, dword 1 reads 0 for function 0 and 0x02800000 for functions 1 to 3.
- R5: In whole-dword mode (default), a write to dword 1 with any byte enable set stores ((old merged with write data under the byte enables) AND 0x00000005) OR 0x02800000; command bits other than 0 and 2 always read 0.
- R6: In whole-dword mode, bytes whose enable is low keep their old value before the masking of R5, and a write with all four enables low changes nothing.
- R7: In per-byte mode, enable bit 0 stores write-data bits 0 and 2 into command byte 0 and clears its other bits; enables 1 and 3 leave bytes 1 and 3 unchanged.
- R8: In per-byte mode, enable bit 2 sets bit 23 of dword 1 and leaves the other bits of byte 2 as they were, whatever the write data; status bits once set stay set.
- R9: A read to function 4 or above returns 0, and a write to one changes no register of any function.
- R10: Writes to dwords 0, 2 and 3 are ignored; dwords 4 and above read 0 and ignore writes.
- R11: rd_valid is high exactly in the cycle after a read request and low otherwise; a write request never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_func | input | FUNC_W | Function number |
| req_dword | input | DW_W | Dword index within the header |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for the write |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |

## Verification
The case that is hardest to reach from the ports is a byte-enable merge whose result depends on a bit that an earlier write left in a byte the current write does not enable: it is only seen when a write with a partial enable follows one that set command bits. The stimulus first sets bit 2 through byte 0, then writes zero with only byte 1 enabled and reads back, expecting bit 2 to survive. A second instance built for the per-byte rule receives its own write sequence, so that the status set and the command mask are exercised apart from the whole-dword rule.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    localparam int NUM_FUNC = 4;
    localparam int NUM_SLOT = 4;
    localparam int DATA_W   = 32;
    localparam int BE_W     = DATA_W / 8;

    typedef enum logic [1:0] {
        SLOT_ID      = 2'd0,
        SLOT_CMDSTAT = 2'd1,
        SLOT_CLASS   = 2'd2,
        SLOT_HDR     = 2'd3
    } slot_e;

    typedef enum logic {
        UPD_DWORD = 1'b0,
        UPD_BYTE  = 1'b1
    } upd_style_e;

    typedef struct packed {
        logic [NUM_FUNC-1:0] fn_hit;
        logic                in_hdr;
        slot_e               slot;
    } decode_t;

    localparam logic [DATA_W-1:0] CMD_KEEP     = 32'h0000_0005;
    localparam logic [DATA_W-1:0] STATUS_FORCE = 32'h0280_0000;
    localparam logic [DATA_W-1:0] MULTI_FN_HDR = 32'h0080_0000;
    localparam int                STATUS_BIT   = 23;
    localparam logic [15:0]       VENDOR_CODE  = 16'h8086;
    localparam logic [15:0]       DEVICE_BASE  = 16'h7110;

    function automatic logic [DATA_W-1:0] class_default(input int fn);
        case (fn)
            0:       return 32'h0601_0000;
            1:       return 32'h0101_8000;
            2:       return 32'h0C03_0000;
            default: return 32'h0680_0000;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] reset_value(input int fn, input slot_e s);
        case (s)
            SLOT_ID:      return {DEVICE_BASE + 16'(fn), VENDOR_CODE};
            SLOT_CMDSTAT: return (fn == 0) ? '0 : STATUS_FORCE;
            SLOT_CLASS:   return class_default(fn);
            default:      return (fn == 0) ? MULTI_FN_HDR : '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] merge_be(input logic [DATA_W-1:0] old_v,
                                                    input logic [DATA_W-1:0] new_v,
                                                    input logic [BE_W-1:0]   be);
        logic [DATA_W-1:0] r;
        for (int b = 0; b < BE_W; b++) begin
            r[b*8 +: 8] = be[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/pcfg_decode.sv
module pcfg_decode
    import pcfg_pkg::*;
#(
    parameter int FUNC_W = 3,
    parameter int DW_W   = 6
) (
    input  logic [FUNC_W-1:0] req_func,
    input  logic [DW_W-1:0]   req_dword,
    output decode_t           dec
);
    localparam int SLOT_W = $clog2(NUM_SLOT);

    always_comb begin
        for (int i = 0; i < NUM_FUNC; i++) begin
            dec.fn_hit[i] = ({1'b0, req_func} == (FUNC_W+1)'(i));
        end
        dec.in_hdr = ({1'b0, req_dword} < (DW_W+1)'(NUM_SLOT));
        dec.slot   = slot_e'(req_dword[SLOT_W-1:0]);
    end
endmodule

// File: rtl/pcfg_bank.sv
module pcfg_bank
    import pcfg_pkg::*;
#(
    parameter int         FUNC_IDX = 0,
    parameter upd_style_e STYLE    = UPD_DWORD
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [DATA_W-1:0]                wdata,
    input  logic [BE_W-1:0]                  be,
    output logic [NUM_SLOT-1:0][DATA_W-1:0]  regs
);
    logic [DATA_W-1:0] cmd_next;
    logic              any_be;

    assign any_be = |be;

    generate
        if (STYLE == UPD_DWORD) begin : g_dword
            always_comb begin
                cmd_next = merge_be(regs[SLOT_CMDSTAT], wdata, be);
                cmd_next = (cmd_next & CMD_KEEP) | STATUS_FORCE;
                if (!any_be) cmd_next = regs[SLOT_CMDSTAT];
            end
        end else begin : g_byte
            always_comb begin
                cmd_next = regs[SLOT_CMDSTAT];
                if (be[0]) cmd_next[7:0] = wdata[7:0] & CMD_KEEP[7:0];
                if (be[2]) cmd_next[STATUS_BIT] = 1'b1;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SLOT; s++) begin
                regs[s] <= reset_value(FUNC_IDX, slot_e'(s));
            end
        end else if (wr_en) begin
            regs[SLOT_CMDSTAT] <= cmd_next;
        end
    end
endmodule

// File: rtl/pcfg_rdmux.sv
module pcfg_rdmux
    import pcfg_pkg::*;
(
    input  logic [NUM_FUNC-1:0][NUM_SLOT-1:0][DATA_W-1:0] banks,
    input  decode_t                                       dec,
    output logic [DATA_W-1:0]                             data
);
    always_comb begin
        data = '0;
        for (int f = 0; f < NUM_FUNC; f++) begin
            if (dec.fn_hit[f] && dec.in_hdr) data = data | banks[f][dec.slot];
        end
    end
endmodule

// File: rtl/pcfg_header.sv
module pcfg_header
    import pcfg_pkg::*;
#(
    parameter int         FUNC_W = 3,
    parameter int         DW_W   = 6,
    parameter upd_style_e STYLE  = UPD_DWORD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [FUNC_W-1:0] req_func,
    input  logic [DW_W-1:0]   req_dword,
    input  logic [31:0]       req_wdata,
    input  logic [3:0]        req_be,
    output logic              rd_valid,
    output logic [31:0]       rd_data
);
    decode_t                                       dec;
    logic [NUM_FUNC-1:0][NUM_SLOT-1:0][DATA_W-1:0] banks;
    logic [DATA_W-1:0]                             mux_data;
    logic                                          cmd_wr;

    pcfg_decode #(.FUNC_W(FUNC_W), .DW_W(DW_W)) u_dec (
        .req_func (req_func),
        .req_dword(req_dword),
        .dec      (dec)
    );

    assign cmd_wr = req_valid && req_write && dec.in_hdr && (dec.slot == SLOT_CMDSTAT);

    generate
        for (genvar f = 0; f < NUM_FUNC; f++) begin : g_fn
            pcfg_bank #(.FUNC_IDX(f), .STYLE(STYLE)) u_bank (
                .clk  (clk),
                .rst  (rst),
                .wr_en(cmd_wr && dec.fn_hit[f]),
                .wdata(req_wdata),
                .be   (req_be),
                .regs (banks[f])
            );
        end
    endgenerate

    pcfg_rdmux u_mux (
        .banks(banks),
        .dec  (dec),
        .data (mux_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= req_valid && !req_write;
            if (req_valid && !req_write) rd_data <= mux_data;
        end
    end
endmodule

// File: rtl/pcfg_header_chk.sv
module pcfg_header_chk
    import pcfg_pkg::*;
#(
    parameter int FUNC_W = 3,
    parameter int DW_W   = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [FUNC_W-1:0] req_func,
    input logic [DW_W-1:0]   req_dword,
    input logic              rd_valid,
    input logic [31:0]       rd_data
);
    logic is_rd, fn_impl, fn_hi;
    assign is_rd   = req_valid && !req_write;
    assign fn_impl = ({1'b0, req_func} < (FUNC_W+1)'(NUM_FUNC));
    assign fn_hi   = ({1'b0, req_func} > (FUNC_W+1)'(0));

    AST_RD_STROBE: assert property (@(posedge clk) disable iff (rst)
        is_rd |=> rd_valid) else $error("rd strobe");                 // R11
    AST_NO_SPURIOUS_RD: assert property (@(posedge clk) disable iff (rst)
        !is_rd |=> !rd_valid) else $error("spurious rd");            // R11
    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (is_rd && !fn_impl) |=> (rd_data == 32'h0)) else $error("unimpl"); // R9
    AST_VENDOR_CONST: assert property (@(posedge clk) disable iff (rst)
        (is_rd && fn_impl && req_dword == '0) |=> (rd_data[15:0] == VENDOR_CODE))
        else $error("vendor");                                        // R1
    AST_CMD_MASKED: assert property (@(posedge clk) disable iff (rst)
        (is_rd && req_dword == DW_W'(1)) |=> ((rd_data[15:0] & 16'hFFFA) == 16'h0))
        else $error("cmd mask");                                      // R5
    AST_STATUS_KEPT: assert property (@(posedge clk) disable iff (rst)
        (is_rd && fn_impl && fn_hi && req_dword == DW_W'(1)) |=> (rd_data[25] && rd_data[23]))
        else $error("status");                                        // R8
    AST_OFF_HDR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (is_rd && ({1'b0, req_dword} >= (DW_W+1)'(NUM_SLOT))) |=> (rd_data == 32'h0))
        else $error("off hdr");                                       // R10
endmodule

bind pcfg_header pcfg_header_chk #(.FUNC_W(FUNC_W), .DW_W(DW_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_func (req_func),
    .req_dword(req_dword),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
);

// File: tb/pcfg_header_test.sv
module pcfg_header_test;
    import pcfg_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        a_valid = 0, a_write = 0;
    logic [2:0]  a_func = 0;
    logic [5:0]  a_dw = 0;
    logic [31:0] a_wd = 0;
    logic [3:0]  a_be = 0;
    logic        a_rv;
    logic [31:0] a_rd;

    logic        b_valid = 0, b_write = 0;
    logic [2:0]  b_func = 0;
    logic [5:0]  b_dw = 0;
    logic [31:0] b_wd = 0;
    logic [3:0]  b_be = 0;
    logic        b_rv;
    logic [31:0] b_rd;

    pcfg_header #(.STYLE(UPD_DWORD)) uut (
        .clk(clk), .rst(rst), .req_valid(a_valid), .req_write(a_write),
        .req_func(a_func), .req_dword(a_dw), .req_wdata(a_wd), .req_be(a_be),
        .rd_valid(a_rv), .rd_data(a_rd));

    pcfg_header #(.STYLE(UPD_BYTE)) uut_b (
        .clk(clk), .rst(rst), .req_valid(b_valid), .req_write(b_write),
        .req_func(b_func), .req_dword(b_dw), .req_wdata(b_wd), .req_be(b_be),
        .rd_valid(b_rv), .rd_data(b_rd));

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // entry: {write, func[2:0], dword[5:0], be[3:0], wdata[31:0], expected[31:0]}
    localparam int NV = 33;
    localparam logic [77:0] VEC [0:NV-1] = '{
        {1'b0, 3'd0, 6'd0, 4'h0, 32'h0, 32'h7110_8086},   // R1
        {1'b0, 3'd1, 6'd0, 4'h0, 32'h0, 32'h7111_8086},   // R1
        {1'b0, 3'd2, 6'd0, 4'h0, 32'h0, 32'h7112_8086},   // R1
        {1'b0, 3'd3, 6'd0, 4'h0, 32'h0, 32'h7113_8086},   // R1
        {1'b0, 3'd0, 6'd2, 4'h0, 32'h0, 32'h0601_0000},   // R2
        {1'b0, 3'd1, 6'd2, 4'h0, 32'h0, 32'h0101_8000},   // R2
        {1'b0, 3'd2, 6'd2, 4'h0, 32'h0, 32'h0C03_0000},   // R2
        {1'b0, 3'd3, 6'd2, 4'h0, 32'h0, 32'h0680_0000},   // R2
        {1'b0, 3'd0, 6'd3, 4'h0, 32'h0, 32'h0080_0000},   // R3
        {1'b0, 3'd2, 6'd3, 4'h0, 32'h0, 32'h0000_0000},   // R3
        {1'b0, 3'd0, 6'd1, 4'h0, 32'h0, 32'h0000_0000},   // R4
        {1'b0, 3'd3, 6'd1, 4'h0, 32'h0, 32'h0280_0000},   // R4
        {1'b0, 3'd4, 6'd0, 4'h0, 32'h0, 32'h0000_0000},   // R9
        {1'b0, 3'd7, 6'd1, 4'h0, 32'h0, 32'h0000_0000},   // R9
        {1'b0, 3'd0, 6'd5, 4'h0, 32'h0, 32'h0000_0000},   // R10
        {1'b1, 3'd0, 6'd1, 4'hF, 32'hFFFF_FFFF, 32'h0},   // R5
        {1'b0, 3'd0, 6'd1, 4'h0, 32'h0, 32'h0280_0005},   // R5
        {1'b1, 3'd0, 6'd1, 4'hF, 32'hFFFF_FFFA, 32'h0},   // R5
        {1'b0, 3'd0, 6'd1, 4'h0, 32'h0, 32'h0280_0000},   // R5
        {1'b1, 3'd1, 6'd1, 4'h1, 32'h0000_0004, 32'h0},   // R6
        {1'b1, 3'd1, 6'd1, 4'h2, 32'h0000_0000, 32'h0},   // R6
        {1'b0, 3'd1, 6'd1, 4'h0, 32'h0, 32'h0280_0004},   // R6
        {1'b1, 3'd1, 6'd1, 4'h0, 32'hFFFF_FFFF, 32'h0},   // R6
        {1'b0, 3'd1, 6'd1, 4'h0, 32'h0, 32'h0280_0004},   // R6
        {1'b1, 3'd2, 6'd0, 4'hF, 32'h0000_0000, 32'h0},   // R10
        {1'b1, 3'd3, 6'd2, 4'hF, 32'h0000_0000, 32'h0},   // R10
        {1'b1, 3'd0, 6'd3, 4'hF, 32'hFFFF_FFFF, 32'h0},   // R10
        {1'b0, 3'd2, 6'd0, 4'h0, 32'h0, 32'h7112_8086},   // R10
        {1'b0, 3'd3, 6'd2, 4'h0, 32'h0, 32'h0680_0000},   // R10
        {1'b0, 3'd0, 6'd3, 4'h0, 32'h0, 32'h0080_0000},   // R10
        {1'b1, 3'd4, 6'd1, 4'hF, 32'hFFFF_FFFF, 32'h0},   // R9
        {1'b0, 3'd0, 6'd1, 4'h0, 32'h0, 32'h0280_0000},   // R9
        {1'b0, 3'd4, 6'd1, 4'h0, 32'h0, 32'h0000_0000}    // R9
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input bit sel, input logic [2:0] f, input logic [5:0] d,
                      input logic [3:0] be, input logic [31:0] wd);
        @(negedge clk);
        if (!sel) begin a_valid = 1; a_write = 1; a_func = f; a_dw = d; a_be = be; a_wd = wd; end
        else      begin b_valid = 1; b_write = 1; b_func = f; b_dw = d; b_be = be; b_wd = wd; end
        @(negedge clk);
        a_valid = 0; b_valid = 0;
    endtask

    task automatic rd(input bit sel, input logic [2:0] f, input logic [5:0] d,
                      input string req, input logic [31:0] exp);
        @(negedge clk);
        if (!sel) begin a_valid = 1; a_write = 0; a_func = f; a_dw = d; end
        else      begin b_valid = 1; b_write = 0; b_func = f; b_dw = d; end
        @(negedge clk);
        a_valid = 0; b_valid = 0;
        check({req, " strobe"}, {31'b0, sel ? b_rv : a_rv}, 32'h1);
        check(req, sel ? b_rd : a_rd, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        check("R11 reset rd_valid", {31'b0, a_rv}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][77]) wr(0, VEC[i][76:74], VEC[i][73:68], VEC[i][67:64], VEC[i][63:32]);
            else rd(0, VEC[i][76:74], VEC[i][73:68], $sformatf("vec%0d", i), VEC[i][31:0]);
        end

        // R11: write must not raise the strobe
        wr(0, 3'd3, 6'd1, 4'h1, 32'h0000_0001);
        check("R11 no strobe after write", {31'b0, a_rv}, 32'h0);
        rd(0, 3'd3, 6'd1, "R5 fn3 cmd", 32'h0280_0001);
        rd(0, 3'd2, 6'd1, "R5 fn2 untouched", 32'h0280_0000);

        // per-byte variant
        rd(1, 3'd0, 6'd1, "R4 byte fn0", 32'h0000_0000);
        wr(1, 3'd0, 6'd1, 4'h1, 32'h0000_00FF);
        rd(1, 3'd0, 6'd1, "R7 cmd mask", 32'h0000_0005);
        wr(1, 3'd0, 6'd1, 4'h4, 32'h0000_0000);
        rd(1, 3'd0, 6'd1, "R8 status set", 32'h0080_0005);
        wr(1, 3'd0, 6'd1, 4'hA, 32'hFFFF_FF00);
        rd(1, 3'd0, 6'd1, "R7 bytes 1 3 kept", 32'h0080_0005);
        wr(1, 3'd0, 6'd1, 4'h4, 32'h0000_0000);
        rd(1, 3'd0, 6'd1, "R8 status sticky", 32'h0080_0005);
        wr(1, 3'd1, 6'd1, 4'h1, 32'h0000_0000);
        rd(1, 3'd1, 6'd1, "R7 fn1 clear cmd", 32'h0280_0000);

        // reset again restores defaults
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk); rst = 0;
        rd(0, 3'd0, 6'd1, "R4 after re-reset", 32'h0000_0000);
        rd(0, 3'd3, 6'd1, "R4 fn3 after re-reset", 32'h0280_0000);
        rd(1, 3'd0, 6'd1, "R4 byte after re-reset", 32'h0000_0000);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule